// File: doc/BRIEF.md
# Resonance lock search controller

This block is the digital half of a loop that keeps an optical ring resonator tuned onto a fixed laser line by adjusting the forward bias on the ring. An outside sensing chain compares the monitored optical power with a level set by a reference DAC and returns a single comparator bit each clock. The controller averages that bit with an up/down counter, nudges a 9-bit bias DAC code by one LSB for each filtered decision, and declares lock once the decisions keep flipping direction, which means the bias is dithering around the point where power equals the reference.

A lock is only the first step. While the extinction-ratio search is enabled, the controller keeps moving the reference code after every lock and locks again. In through-port mode it moves the code toward lower power. In drop-port mode it moves the code toward higher power. Eventually a lock attempt fails, either because the bias code runs into a rail or because the decisions stop reversing. The controller then puts back the reference code and the bias code of the last good lock, locks there one final time, and reports done. A dynamic mode uses a sixteen-times-longer averaging window so that the loop can run while live data is modulating the ring. When the search is disabled, the controller makes a single lock at the starting reference and stops.

Top module: `rlock_ctrl`

## Requirements
- R1: Reset values: bias code is half scale (256), reference code is 0, and both locked and done are low.
- R2: A steady comparator level moves the bias code by exactly one LSB every 16 clocks in static mode (`dyn_i`=0) and every 256 clocks in dynamic mode (`dyn_i`=1). While an attempt runs, the bias code never changes by more than one LSB per clock.
- R3: A comparator value of 1 means the monitored power is above the reference. In through-port mode (`drop_i`=0), a filtered 1 raises the bias code. In drop-port mode (`drop_i`=1), a filtered 1 lowers it.
- R4: An attempt locks after 8 consecutive filtered decisions that each reverse the previous one. The reference code does not change during an attempt.
- R5: An attempt fails, with the bias code left unchanged, when a decision would step the bias code below 0 or above 511.
- R6: An attempt fails, with the bias code left unchanged, when `stall_lim_i` consecutive decisions pass without a reversal.
- R7: In through-port mode with the search on, each lock lowers the reference code by `step_i`, saturating at 0, and a new attempt starts.
- R8: In drop-port mode with the search on, each lock raises the reference code by `step_i`, saturating at 511, and a new attempt starts.
- R9: When an attempt fails after at least one lock, the reference and bias codes of the last lock are restored and a final attempt runs. If it locks, done and locked both end high.
- R10: When the first attempt fails, done goes high with locked low, and the reference code stays at `init_ref_i`.
- R11: With `search_i`=0, the controller finishes after the first lock at `init_ref_i`, with locked high.
- R12: When a lock happens and the stepped reference would equal the current one (already saturated), the controller finishes with locked high instead of starting another attempt.
- R13: After done, all outputs hold until the next start. A start pulse while an attempt is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new search; accepted only when idle or done |
| dyn_i | input | 1 | 1 selects the long averaging window (live-data tuning) |
| drop_i | input | 1 | 1 selects drop-port monitoring (maximise power) |
| search_i | input | 1 | 1 enables the extinction-ratio reference search |
| init_ref_i | input | 9 | Starting reference DAC code |
| step_i | input | 9 | Reference code step applied after each lock |
| stall_lim_i | input | 9 | Decisions allowed without a reversal before an attempt fails |
| cmp_i | input | 1 | Comparator: 1 when monitored power is above the reference |
| bias_code_o | output | 9 | Bias DAC code driving the resonator |
| ref_code_o | output | 9 | Reference DAC code |
| locked_o | output | 1 | High with done when the final attempt locked |
| done_o | output | 1 | Search finished |

## Verification
Two events can land on the same filtered decision: a lock succeeding, and the reference step saturating at the value it already has. The bench provokes this in through-port mode with a plant that has no power floor. Starting at reference 20 with a step of 10, the search reaches reference 0, which still locks at the resonance null, and the next step has nowhere to go. The correct outcome is an immediate finish with locked high and reference 0. The floored-plant search is the contrast case: there the last step does change the reference, the next attempt fails, and the earlier reference is restored. The plant in the bench is a V-shaped or inverted-V power curve evaluated from the live bias and reference codes.

// File: rtl/rlock_pkg.sv
package rlock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEEK,
    ST_NEXT,
    ST_RESTORE,
    ST_FINAL,
    ST_DONE
  } rlock_st_t;
endpackage

// File: rtl/rlock_filter.sv
// Up/down averaging counter: one decision per LEN samples of net imbalance.
module rlock_filter #(
  parameter int LEN_S = 16,
  parameter int LEN_D = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic dyn,
  input  logic sample,
  output logic dec_v,
  output logic dec_hi
);
  localparam int CW = $clog2(LEN_D) + 2;
  localparam logic signed [CW-1:0] LIM_S = CW'(LEN_S);
  localparam logic signed [CW-1:0] LIM_D = CW'(LEN_D);
  localparam logic signed [CW-1:0] ONE   = CW'(1);

  logic signed [CW-1:0] cnt, cnt_nxt, lim;

  assign lim     = dyn ? LIM_D : LIM_S;
  assign cnt_nxt = sample ? cnt + ONE : cnt - ONE;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      dec_v  <= 1'b0;
      dec_hi <= 1'b0;
    end else begin
      dec_v <= 1'b0;
      if (cnt_nxt == lim) begin
        cnt    <= '0;
        dec_v  <= 1'b1;
        dec_hi <= 1'b1;
      end else if (cnt_nxt == -lim) begin
        cnt    <= '0;
        dec_v  <= 1'b1;
        dec_hi <= 1'b0;
      end else begin
        cnt <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/rlock_detect.sv
// Tracks reversals of filtered decisions: lock on a run of reversals,
// stall when too many decisions pass without one.
module rlock_detect #(
  parameter int ALT_N = 8,
  parameter int TO_W  = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            dec_v,
  input  logic            dec_hi,
  input  logic [TO_W-1:0] stall_lim,
  output logic            lock_hit,
  output logic            stall_hit
);
  localparam int AW = $clog2(ALT_N + 1);

  logic            have_last, last_hi, rev;
  logic [AW-1:0]   alt_cnt;
  logic [TO_W-1:0] stall;

  assign rev       = have_last && (dec_hi != last_hi);
  assign lock_hit  = dec_v && rev && (alt_cnt == AW'(ALT_N - 1));
  assign stall_hit = dec_v && !rev &&
                     (({1'b0, stall} + (TO_W+1)'(1)) >= {1'b0, stall_lim});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      have_last <= 1'b0;
      last_hi   <= 1'b0;
      alt_cnt   <= '0;
      stall     <= '0;
    end else if (dec_v) begin
      have_last <= 1'b1;
      last_hi   <= dec_hi;
      if (rev) begin
        if (alt_cnt != AW'(ALT_N)) alt_cnt <= alt_cnt + AW'(1);
        stall <= '0;
      end else begin
        alt_cnt <= '0;
        if (stall != '1) stall <= stall + TO_W'(1);
      end
    end
  end
endmodule

// File: rtl/rlock_ctrl.sv
module rlock_ctrl #(
  parameter int BIAS_W = 9,
  parameter int REF_W  = 9,
  parameter int ALT_N  = 8,
  parameter int LEN_S  = 16,
  parameter int LEN_D  = 256,
  parameter int TO_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dyn_i,
  input  logic              drop_i,
  input  logic              search_i,
  input  logic [REF_W-1:0]  init_ref_i,
  input  logic [REF_W-1:0]  step_i,
  input  logic [TO_W-1:0]   stall_lim_i,
  input  logic              cmp_i,
  output logic [BIAS_W-1:0] bias_code_o,
  output logic [REF_W-1:0]  ref_code_o,
  output logic              locked_o,
  output logic              done_o
);
  import rlock_pkg::*;

  localparam logic [BIAS_W-1:0] BIAS_MAX = '1;
  localparam logic [BIAS_W-1:0] BIAS_MID = {1'b1, {(BIAS_W-1){1'b0}}};
  localparam logic [REF_W-1:0]  REF_MAX  = '1;

  rlock_st_t        st;
  logic             dyn_q, drop_q, search_q;
  logic [REF_W-1:0] step_q, ref_q, good_ref, ref_nxt;
  logic [TO_W-1:0]  lim_q;
  logic [BIAS_W-1:0] bias_q, good_bias;
  logic             have_good, locked_q, done_q;
  logic             busy, dec_v, dec_hi, lock_hit, stall_hit, bias_up, at_rail;
  logic [REF_W:0]   ref_sum;

  assign busy = (st == ST_SEEK) || (st == ST_FINAL);

  rlock_filter #(.LEN_S(LEN_S), .LEN_D(LEN_D)) u_filt (
    .clk(clk), .rst(rst), .clr(!busy), .dyn(dyn_q), .sample(cmp_i),
    .dec_v(dec_v), .dec_hi(dec_hi)
  );

  rlock_detect #(.ALT_N(ALT_N), .TO_W(TO_W)) u_det (
    .clk(clk), .rst(rst), .clr(!busy), .dec_v(dec_v), .dec_hi(dec_hi),
    .stall_lim(lim_q), .lock_hit(lock_hit), .stall_hit(stall_hit)
  );

  // Power above reference: raise bias in through-port, lower it in drop-port.
  assign bias_up = dec_hi ^ drop_q;
  assign at_rail = bias_up ? (bias_q == BIAS_MAX) : (bias_q == '0);

  // Next reference: toward lower power (through) or higher power (drop).
  assign ref_sum = {1'b0, ref_q} + {1'b0, step_q};
  always_comb begin
    if (drop_q) ref_nxt = ref_sum[REF_W] ? REF_MAX : ref_sum[REF_W-1:0];
    else        ref_nxt = (ref_q >= step_q) ? (ref_q - step_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      dyn_q     <= 1'b0;
      drop_q    <= 1'b0;
      search_q  <= 1'b0;
      step_q    <= '0;
      lim_q     <= '0;
      ref_q     <= '0;
      bias_q    <= BIAS_MID;
      good_ref  <= '0;
      good_bias <= BIAS_MID;
      have_good <= 1'b0;
      locked_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            dyn_q     <= dyn_i;
            drop_q    <= drop_i;
            search_q  <= search_i;
            step_q    <= step_i;
            lim_q     <= stall_lim_i;
            ref_q     <= init_ref_i;
            bias_q    <= BIAS_MID;
            have_good <= 1'b0;
            locked_q  <= 1'b0;
            done_q    <= 1'b0;
            st        <= ST_SEEK;
          end
        end
        ST_SEEK, ST_FINAL: begin
          if (dec_v) begin
            if (lock_hit) begin
              good_ref  <= ref_q;
              good_bias <= bias_q;
              have_good <= 1'b1;
              if (st == ST_FINAL || !search_q || ref_nxt == ref_q) begin
                locked_q <= 1'b1;
                done_q   <= 1'b1;
                st       <= ST_DONE;
              end else begin
                ref_q <= ref_nxt;
                st    <= ST_NEXT;
              end
            end else if (at_rail || stall_hit) begin
              if (st == ST_SEEK && have_good) begin
                st <= ST_RESTORE;
              end else begin
                done_q <= 1'b1;
                st     <= ST_DONE;
              end
            end else if (bias_up) begin
              bias_q <= bias_q + BIAS_W'(1);
            end else begin
              bias_q <= bias_q - BIAS_W'(1);
            end
          end
        end
        ST_NEXT: st <= ST_SEEK;
        ST_RESTORE: begin
          ref_q  <= good_ref;
          bias_q <= good_bias;
          st     <= ST_FINAL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bias_code_o = bias_q;
  assign ref_code_o  = ref_q;
  assign locked_o    = locked_q;
  assign done_o      = done_q;
endmodule

// File: rtl/rlock_chk.sv
module rlock_chk #(
  parameter int BIAS_W = 9,
  parameter int REF_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              start,
  input logic [BIAS_W-1:0] bias,
  input logic [REF_W-1:0]  ref_code,
  input logic              locked,
  input logic              done
);
  logic              prev_busy;
  logic [BIAS_W-1:0] prev_bias;
  logic [REF_W-1:0]  prev_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_busy <= 1'b0;
      prev_bias <= '0;
      prev_ref  <= '0;
    end else begin
      prev_busy <= busy;
      prev_bias <= bias;
      prev_ref  <= ref_code;
    end
  end

  AST_BIAS_SLEW: assert property (@(posedge clk) disable iff (rst)
    (busy && prev_busy) |-> ((bias == prev_bias) ||
                             ({1'b0, bias} == {1'b0, prev_bias} + (BIAS_W+1)'(1)) ||
                             ({1'b0, bias} + (BIAS_W+1)'(1) == {1'b0, prev_bias}))); // R2

  AST_REF_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && prev_busy) |-> (ref_code == prev_ref)); // R4

  AST_LOCK_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    locked |-> done); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(bias) && $stable(ref_code) && $stable(locked))); // R13

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R13
endmodule

bind rlock_ctrl rlock_chk #(.BIAS_W(BIAS_W), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .start(start_i),
  .bias(bias_q), .ref_code(ref_q), .locked(locked_q), .done(done_q)
);

// File: tb/rlock_ctrl_tb.sv
module rlock_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, dyn_i = 1'b0, drop_i = 1'b0, search_i = 1'b0;
  logic [8:0] init_ref_i = '0, step_i = '0, stall_lim_i = '0;
  logic       cmp_i;
  logic [8:0] bias_code_o, ref_code_o;
  logic       locked_o, done_o;

  int checks = 0;
  int errors = 0;

  // Plant: V-shaped through-port power or inverted-V drop-port power.
  int p_tgt   = 300;
  int p_floor = 5;
  int p_peak  = 100;
  bit p_drop  = 1'b0;

  always #4 clk = ~clk;

  rlock_ctrl u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .dyn_i(dyn_i), .drop_i(drop_i),
    .search_i(search_i), .init_ref_i(init_ref_i), .step_i(step_i),
    .stall_lim_i(stall_lim_i), .cmp_i(cmp_i), .bias_code_o(bias_code_o),
    .ref_code_o(ref_code_o), .locked_o(locked_o), .done_o(done_o)
  );

  always_comb begin
    int b, d, pw;
    b  = int'(bias_code_o);
    d  = (b > p_tgt) ? b - p_tgt : p_tgt - b;
    pw = p_drop ? p_peak - d : d + p_floor;
    cmp_i = (pw > int'(ref_code_o));
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic kick(input bit dyn, input bit drop, input bit srch,
                      input int iref, input int stp, input int lim);
    @(negedge clk);
    dyn_i = dyn; drop_i = drop; search_i = srch;
    init_ref_i = 9'(iref); step_i = 9'(stp); stall_lim_i = 9'(lim);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 60000) begin
      @(negedge clk);
      n++;
    end
    chk(done_o, tag, int'(done_o), 1);
  endtask

  // Cycles between two consecutive bias code changes after the first one.
  task automatic step_period(output int per, output int first_val);
    logic [8:0] prev;
    int n = 0;
    while (bias_code_o == 9'd256 && n < 2000) begin @(negedge clk); n++; end
    first_val = int'(bias_code_o);
    prev = bias_code_o;
    per = 0;
    while (bias_code_o == prev && per < 2000) begin @(negedge clk); per++; end
  endtask

  task automatic t_reset;
    chk(bias_code_o == 9'd256, "R1 bias", int'(bias_code_o), 256);
    chk(ref_code_o == 9'd0, "R1 ref", int'(ref_code_o), 0);
    chk(!locked_o && !done_o, "R1 flags", int'({locked_o, done_o}), 0);
  endtask

  task automatic t_static_single;
    int per, fv, lo;
    p_drop = 1'b0; p_floor = 5;
    kick(1'b0, 1'b0, 1'b0, 35, 10, 64);
    step_period(per, fv);
    chk(fv == 257, "R3 through raises bias", fv, 257);
    chk(per == 16, "R2 static period", per, 16);
    wait_done("R11 done");
    lo = p_tgt + p_floor - 35 - 1;
    chk(locked_o, "R11 locked", int'(locked_o), 1);
    chk(ref_code_o == 9'd35, "R11 ref kept", int'(ref_code_o), 35);
    chk(int'(bias_code_o) >= lo && int'(bias_code_o) <= lo + 1, "R4 lock point",
        int'(bias_code_o), lo);
  endtask

  task automatic t_dynamic_single;
    int per, fv;
    p_drop = 1'b0; p_floor = 5;
    kick(1'b1, 1'b0, 1'b0, 35, 10, 64);
    step_period(per, fv);
    chk(per == 256, "R2 dynamic period", per, 256);
    wait_done("R2 dynamic done");
    chk(locked_o, "R2 dynamic locked", int'(locked_o), 1);
  endtask

  task automatic t_search_through;
    int lo;
    p_drop = 1'b0; p_floor = 5;
    kick(1'b0, 1'b0, 1'b1, 35, 10, 64);
    repeat (50) @(negedge clk);
    // start while busy with different settings: must be ignored
    init_ref_i = 9'd100; drop_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R7 done");
    // refs 35,25,15,5 lock; 0 is below the floor and fails; 5 restored
    lo = p_tgt - 1;
    chk(ref_code_o == 9'd5, "R7 final ref", int'(ref_code_o), 5);
    chk(locked_o, "R9 final locked", int'(locked_o), 1);
    chk(int'(bias_code_o) >= lo && int'(bias_code_o) <= lo + 1, "R9 restored bias",
        int'(bias_code_o), lo);
    begin
      logic [8:0] b0, r0;
      b0 = bias_code_o; r0 = ref_code_o;
      repeat (40) @(negedge clk);
      chk(bias_code_o == b0 && ref_code_o == r0 && done_o && locked_o,
          "R13 hold after done", int'(bias_code_o), int'(b0));
    end
  endtask

  task automatic t_search_drop;
    int per, fv, lo;
    p_drop = 1'b1; p_peak = 100;
    kick(1'b0, 1'b1, 1'b1, 40, 10, 64);
    step_period(per, fv);
    chk(fv == 255, "R3 drop lowers bias", fv, 255);
    wait_done("R8 done");
    // refs 40..90 lock; 100 is never exceeded and fails; 90 restored
    lo = p_tgt - (p_peak - 90);
    chk(ref_code_o == 9'd90, "R8 final ref", int'(ref_code_o), 90);
    chk(locked_o, "R9 drop locked", int'(locked_o), 1);
    chk(int'(bias_code_o) >= lo && int'(bias_code_o) <= lo + 1, "R8 lock point",
        int'(bias_code_o), lo);
  endtask

  task automatic t_saturate_done;
    p_drop = 1'b0; p_floor = 0;
    kick(1'b0, 1'b0, 1'b1, 20, 10, 64);
    wait_done("R12 done");
    chk(ref_code_o == 9'd0, "R12 ref at zero", int'(ref_code_o), 0);
    chk(locked_o, "R12 locked", int'(locked_o), 1);
    chk(int'(bias_code_o) >= p_tgt - 1 && int'(bias_code_o) <= p_tgt, "R12 bias",
        int'(bias_code_o), p_tgt);
  endtask

  task automatic t_stall_fail;
    p_drop = 1'b0; p_floor = 5;
    kick(1'b0, 1'b0, 1'b1, 2, 10, 4);
    wait_done("R6 done");
    chk(bias_code_o == 9'd259, "R6 stall bias", int'(bias_code_o), 259);
    chk(!locked_o, "R10 not locked", int'(locked_o), 0);
    chk(ref_code_o == 9'd2, "R10 ref kept", int'(ref_code_o), 2);
  endtask

  task automatic t_rail_fail;
    p_drop = 1'b0; p_floor = 5;
    kick(1'b0, 1'b0, 1'b1, 2, 10, 511);
    wait_done("R5 done");
    chk(bias_code_o == 9'd511, "R5 rail bias", int'(bias_code_o), 511);
    chk(!locked_o, "R5 not locked", int'(locked_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_static_single();
    t_dynamic_single();
    t_search_through();
    t_search_drop();
    t_saturate_done();
    t_stall_fail();
    t_rail_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule